// File: doc/BRIEF.md
# IDE Data-Port Read Prefetcher

This block sits between the I/O slave of a PCI target and an internal read-request channel. It answers reads of the disk data port at 1F0h. It also listens to writes on the command port at 1F7h and decodes the opcode to learn whether the drive is running a read command. While prefetching is switched on and a read command is active, the block sends internal read requests ahead of any PCI demand. It keeps the returned dwords in a short queue and hands them to the PCI reads that follow.

The prefetch stays inside one 512-byte sector. A new command write drops every queued dword and restarts the sector count. Each request carries a one-bit epoch tag. A response whose tag no longer matches was issued before the last command write, so it is thrown away. When prefetching does not apply, a data-port read sends exactly one demand request and is told to retry until that dword has come back.

Top module: `ide_rd_prefetch`

## Requirements
- R1: After reset the block shows no PCI response (`pio_ack_o`, `pio_retry_o` and `pio_size_err_o` are all 0) and no internal request (`req_valid_o` is 0).
- R2: On each command-port write the block latches `mode_i`. Code 2'b01 keeps two dwords in flight or queued, 2'b10 keeps three, and 2'b00 and the reserved code 2'b11 disable prefetch.
- R3: Prefetch runs only when the last byte written to the command port (`pio_wdata_i[7:0]`) is 20h, C4h or E4h. Every other opcode keeps the block from issuing requests on its own.
- R4: While prefetching, the number of queued dwords plus outstanding requests is held at the configured depth. Each dword consumed by a PCI read triggers exactly one replacement request.
- R5: After one command write, at most 128 prefetch requests (512 bytes in dwords) are issued. The count starts again from zero only on the next command write.
- R6: A command-port write empties the queue. The epoch tag (`req_epoch_o`) is 0 after reset and toggles on every command write. A response whose `rsp_epoch_i` differs from the current tag is dropped.
- R7: A data-port read gets its answer in the next cycle. If a queued dword exists, the answer is an acknowledge with the oldest queued dword. Otherwise it is a retry, and a retry is given whatever the prefetch setting.
- R8: While prefetch is enabled (latched code 01 or 10), a data-port read whose byte enables are not 4'b1111 is answered with `pio_size_err_o` and consumes nothing. With prefetch disabled, partial reads are served normally.
- R9: When prefetch is inactive or the sector limit has been reached, a read that finds the queue empty and nothing outstanding issues one demand request. Later reads retry until that dword arrives and then return it.
- R10: Changing `mode_i` without a command write does not affect the current command.
- R11: While `req_ready_i` is low, `req_valid_o` and `req_epoch_o` stay unchanged until a command write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Prefetch setting, latched on command write |
| pio_valid_i | input | 1 | PCI-side I/O access strobe, one cycle per access |
| pio_write_i | input | 1 | 1 = write, 0 = read |
| pio_addr_i | input | ADDR_W | I/O port address |
| pio_be_i | input | DATA_W/8 | Byte enables of the access |
| pio_wdata_i | input | DATA_W | Write data; bits 7:0 carry the command opcode |
| pio_ack_o | output | 1 | Access completed (read data valid for data-port reads) |
| pio_retry_o | output | 1 | Access must be retried |
| pio_size_err_o | output | 1 | Partial data-port read while prefetch enabled |
| pio_rdata_o | output | DATA_W | Read data returned with acknowledge |
| req_valid_o | output | 1 | Internal read request pending |
| req_ready_i | input | 1 | Internal channel accepts the request |
| req_epoch_o | output | 1 | Epoch tag carried by the request |
| rsp_valid_i | input | 1 | Internal read data returned |
| rsp_data_i | input | DATA_W | Returned dword |
| rsp_epoch_i | input | 1 | Epoch tag of the returned dword |

## Verification
The main function is driven by sweeping every mode code against a set of read and non-read opcodes. Counting the requests that appear while the block is idle separates depth two, depth three and no prefetch. Runs of back-to-back consumed reads at both depths show that replacement keeps the pipeline topped up. A full-sector run shows that issuing stops at exactly 128 and then falls back to demand. Command writes made while responses are still in flight, together with a responder that stamps every dword with its epoch and per-command index, show whether stale data leaks into the queue and whether ordering survives a flush.

// File: rtl/ide_pf_pkg.sv
package ide_pf_pkg;

    typedef enum logic [1:0] {
        PF_OFF   = 2'b00,
        PF_TWO   = 2'b01,
        PF_THREE = 2'b10,
        PF_RSVD  = 2'b11
    } pf_mode_e;

    typedef enum logic [1:0] {
        RSP_NONE  = 2'b00,
        RSP_ACK   = 2'b01,
        RSP_RETRY = 2'b10,
        RSP_SIZE  = 2'b11
    } rsp_kind_e;

    function automatic logic is_read_opcode(input logic [7:0] op);
        return (op == 8'h20) || (op == 8'hC4) || (op == 8'hE4);
    endfunction

    function automatic logic [1:0] mode_depth(input pf_mode_e m);
        case (m)
            PF_TWO:   return 2'd2;
            PF_THREE: return 2'd3;
            default:  return 2'd0;
        endcase
    endfunction

    function automatic logic mode_enabled(input pf_mode_e m);
        return (m == PF_TWO) || (m == PF_THREE);
    endfunction

endpackage

// File: rtl/ide_pf_cmd.sv
module ide_pf_cmd
    import ide_pf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_wr_i,
    input  logic [7:0] opcode_i,
    input  logic [1:0] mode_i,
    output logic       active_o,
    output logic       mode_on_o,
    output logic [1:0] depth_o,
    output logic       epoch_o
);

    typedef struct packed {
        logic     epoch;
        logic     rd_op;
        pf_mode_e mode;
    } cmd_t;

    cmd_t cmd_d, cmd_q;

    always_comb begin
        cmd_d = cmd_q;
        if (cmd_wr_i) begin
            cmd_d.epoch = ~cmd_q.epoch;
            cmd_d.rd_op = is_read_opcode(opcode_i);
            cmd_d.mode  = pf_mode_e'(mode_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cmd_q <= '{epoch: 1'b0, rd_op: 1'b0, mode: PF_OFF};
        else        cmd_q <= cmd_d;
    end

    assign mode_on_o = mode_enabled(cmd_q.mode);
    assign active_o  = mode_on_o && cmd_q.rd_op;
    assign depth_o   = mode_depth(cmd_q.mode);
    assign epoch_o   = cmd_q.epoch;

endmodule

// File: rtl/ide_pf_queue.sv
module ide_pf_queue #(
    parameter int DEPTH = 4,
    parameter int W     = 32,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush_i,
    input  logic          push_i,
    input  logic [W-1:0]  data_i,
    input  logic          pop_i,
    output logic [W-1:0]  head_o,
    output logic [CW-1:0] count_o
);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           rd;
        logic [AW-1:0]           wr;
        logic [CW-1:0]           cnt;
    } q_t;

    q_t q_d, q_q;
    logic do_push, do_pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        q_d     = q_q;
        do_pop  = pop_i && (q_q.cnt != '0);
        do_push = push_i && ((q_q.cnt != CW'(DEPTH)) || do_pop);
        if (flush_i) begin
            q_d.rd  = '0;
            q_d.wr  = '0;
            q_d.cnt = '0;
        end else begin
            if (do_push) begin
                q_d.mem[q_q.wr] = data_i;
                q_d.wr          = bump(q_q.wr);
            end
            if (do_pop) q_d.rd = bump(q_q.rd);
            case ({do_push, do_pop})
                2'b10:   q_d.cnt = q_q.cnt + CW'(1);
                2'b01:   q_d.cnt = q_q.cnt - CW'(1);
                default: q_d.cnt = q_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign head_o  = q_q.mem[q_q.rd];
    assign count_o = q_q.cnt;

endmodule

// File: rtl/ide_pf_sector.sv
module ide_pf_sector #(
    parameter int SECTOR_DW = 128,
    localparam int OW       = $clog2(SECTOR_DW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          step_i,
    output logic          room_o,
    output logic [OW-1:0] off_o
);

    typedef struct packed {
        logic [OW-1:0] off;
    } sec_t;

    sec_t sec_d, sec_q;

    always_comb begin
        sec_d = sec_q;
        if (clear_i)     sec_d.off = '0;
        else if (step_i) sec_d.off = sec_q.off + OW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sec_q <= '0;
        else        sec_q <= sec_d;
    end

    assign room_o = sec_q.off < OW'(SECTOR_DW);
    assign off_o  = sec_q.off;

endmodule

// File: rtl/ide_rd_prefetch.sv
module ide_rd_prefetch
    import ide_pf_pkg::*;
#(
    parameter int              ADDR_W       = 16,
    parameter int              DATA_W       = 32,
    parameter int              QUEUE_DEPTH  = 4,
    parameter int              SECTOR_BYTES = 512,
    parameter logic [ADDR_W-1:0] DATA_PORT  = 16'h01F0,
    parameter logic [ADDR_W-1:0] CMD_PORT   = 16'h01F7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic              pio_valid_i,
    input  logic              pio_write_i,
    input  logic [ADDR_W-1:0] pio_addr_i,
    input  logic [DATA_W/8-1:0] pio_be_i,
    input  logic [DATA_W-1:0] pio_wdata_i,
    output logic              pio_ack_o,
    output logic              pio_retry_o,
    output logic              pio_size_err_o,
    output logic [DATA_W-1:0] pio_rdata_o,
    output logic              req_valid_o,
    input  logic              req_ready_i,
    output logic              req_epoch_o,
    input  logic              rsp_valid_i,
    input  logic [DATA_W-1:0] rsp_data_i,
    input  logic              rsp_epoch_i
);

    localparam int BE_W      = DATA_W / 8;
    localparam int SECTOR_DW = SECTOR_BYTES / BE_W;
    localparam int CW        = $clog2(QUEUE_DEPTH + 1);
    localparam int OCW       = CW + 1;
    localparam int OW        = $clog2(SECTOR_DW + 1);

    typedef struct packed {
        logic [CW-1:0]     outst;
        logic              dem_want;
        rsp_kind_e         kind;
        logic [DATA_W-1:0] rdata;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic          cmd_active, cmd_mode_on, cur_epoch;
    logic [1:0]    cmd_depth;
    logic [CW-1:0] q_cnt;
    logic [DATA_W-1:0] q_head;
    logic          sec_room;
    logic [OW-1:0] sec_off;

    logic          data_rd, cmd_wr, size_ok;
    logic [OCW-1:0] occ;
    logic          pf_want, req_fire, take, pop;

    ide_pf_cmd u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_wr_i  (cmd_wr),
        .opcode_i  (pio_wdata_i[7:0]),
        .mode_i    (mode_i),
        .active_o  (cmd_active),
        .mode_on_o (cmd_mode_on),
        .depth_o   (cmd_depth),
        .epoch_o   (cur_epoch)
    );

    ide_pf_queue #(.DEPTH(QUEUE_DEPTH), .W(DATA_W)) u_queue (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush_i (cmd_wr),
        .push_i  (take),
        .data_i  (rsp_data_i),
        .pop_i   (pop),
        .head_o  (q_head),
        .count_o (q_cnt)
    );

    ide_pf_sector #(.SECTOR_DW(SECTOR_DW)) u_sector (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (cmd_wr),
        .step_i  (req_fire && pf_want),
        .room_o  (sec_room),
        .off_o   (sec_off)
    );

    always_comb begin
        ctl_d    = ctl_q;
        data_rd  = pio_valid_i && !pio_write_i && (pio_addr_i == DATA_PORT);
        cmd_wr   = pio_valid_i &&  pio_write_i && (pio_addr_i == CMD_PORT);
        size_ok  = !cmd_mode_on || (pio_be_i == {BE_W{1'b1}});
        occ      = OCW'(q_cnt) + OCW'(ctl_q.outst);
        pf_want  = cmd_active && sec_room && (occ < OCW'(cmd_depth));
        req_fire = (pf_want || ctl_q.dem_want) && req_ready_i;
        take     = rsp_valid_i && (rsp_epoch_i == cur_epoch)
                   && (ctl_q.outst != '0) && !cmd_wr;
        pop      = data_rd && size_ok && (q_cnt != '0);

        // outstanding request count
        if (cmd_wr) begin
            ctl_d.outst = '0;
        end else begin
            case ({req_fire, take})
                2'b10:   ctl_d.outst = ctl_q.outst + CW'(1);
                2'b01:   ctl_d.outst = ctl_q.outst - CW'(1);
                default: ctl_d.outst = ctl_q.outst;
            endcase
        end

        // demand request when prefetch does not cover the read
        if (cmd_wr) begin
            ctl_d.dem_want = 1'b0;
        end else if (ctl_q.dem_want) begin
            if (req_fire) ctl_d.dem_want = 1'b0;
        end else if (data_rd && size_ok && (q_cnt == '0)
                     && !(cmd_active && sec_room) && (ctl_q.outst == '0)) begin
            ctl_d.dem_want = 1'b1;
        end

        // registered PCI-side response
        ctl_d.rdata = '0;
        if (data_rd) begin
            if (!size_ok) begin
                ctl_d.kind = RSP_SIZE;
            end else if (q_cnt != '0) begin
                ctl_d.kind  = RSP_ACK;
                ctl_d.rdata = q_head;
            end else begin
                ctl_d.kind = RSP_RETRY;
            end
        end else if (cmd_wr) begin
            ctl_d.kind = RSP_ACK;
        end else begin
            ctl_d.kind = RSP_NONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{outst: '0, dem_want: 1'b0, kind: RSP_NONE, rdata: '0};
        else        ctl_q <= ctl_d;
    end

    assign req_valid_o    = pf_want || ctl_q.dem_want;
    assign req_epoch_o    = cur_epoch;
    assign pio_ack_o      = (ctl_q.kind == RSP_ACK);
    assign pio_retry_o    = (ctl_q.kind == RSP_RETRY);
    assign pio_size_err_o = (ctl_q.kind == RSP_SIZE);
    assign pio_rdata_o    = ctl_q.rdata;

endmodule

// File: rtl/ide_pf_chk.sv
module ide_pf_chk #(
    parameter int                ADDR_W    = 16,
    parameter int                CW        = 3,
    parameter int                OW        = 8,
    parameter int                SECTOR_DW = 128,
    parameter logic [ADDR_W-1:0] CMD_PORT  = 16'h01F7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pio_valid_i,
    input logic              pio_write_i,
    input logic [ADDR_W-1:0] pio_addr_i,
    input logic              pio_ack_o,
    input logic              pio_retry_o,
    input logic              pio_size_err_o,
    input logic              req_valid_o,
    input logic              req_ready_i,
    input logic              req_epoch_o,
    input logic [CW-1:0]     q_cnt,
    input logic [CW-1:0]     outst,
    input logic [OW-1:0]     sec_off
);

    logic cmd_wr_seen;
    assign cmd_wr_seen = pio_valid_i && pio_write_i && (pio_addr_i == CMD_PORT);

    // R7
    rsp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pio_ack_o, pio_retry_o, pio_size_err_o}));

    // R7
    rsp_follows_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pio_ack_o || pio_retry_o || pio_size_err_o) |-> $past(pio_valid_i));

    // R4
    pipe_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, q_cnt} + {1'b0, outst}) <= (CW + 1)'(3));

    // R6
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr_seen |=> (q_cnt == '0) && (outst == '0) && (sec_off == '0));

    // R5
    sector_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_off <= OW'(SECTOR_DW));

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && !req_ready_i && !cmd_wr_seen) |=> (req_valid_o && $stable(req_epoch_o)));

endmodule

bind ide_rd_prefetch ide_pf_chk #(
    .ADDR_W    (ADDR_W),
    .CW        (CW),
    .OW        (OW),
    .SECTOR_DW (SECTOR_DW),
    .CMD_PORT  (CMD_PORT)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .pio_valid_i    (pio_valid_i),
    .pio_write_i    (pio_write_i),
    .pio_addr_i     (pio_addr_i),
    .pio_ack_o      (pio_ack_o),
    .pio_retry_o    (pio_retry_o),
    .pio_size_err_o (pio_size_err_o),
    .req_valid_o    (req_valid_o),
    .req_ready_i    (req_ready_i),
    .req_epoch_o    (req_epoch_o),
    .q_cnt          (q_cnt),
    .outst          (ctl_q.outst),
    .sec_off        (sec_off)
);

// File: tb/sim_ide_rd_prefetch.sv
module sim_ide_rd_prefetch;

    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] DPORT = 16'h01F0;
    localparam logic [15:0] CPORT = 16'h01F7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode_i = 2'b00;
    logic        pio_valid_i = 1'b0;
    logic        pio_write_i = 1'b0;
    logic [15:0] pio_addr_i = '0;
    logic [3:0]  pio_be_i = '0;
    logic [31:0] pio_wdata_i = '0;
    logic        pio_ack_o, pio_retry_o, pio_size_err_o;
    logic [31:0] pio_rdata_o;
    logic        req_valid_o;
    logic        req_ready_i = 1'b1;
    logic        req_epoch_o;
    logic        rsp_valid_i = 1'b0;
    logic [31:0] rsp_data_i = '0;
    logic        rsp_epoch_i = 1'b0;

    ide_rd_prefetch u0 (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
        .pio_valid_i(pio_valid_i), .pio_write_i(pio_write_i),
        .pio_addr_i(pio_addr_i), .pio_be_i(pio_be_i), .pio_wdata_i(pio_wdata_i),
        .pio_ack_o(pio_ack_o), .pio_retry_o(pio_retry_o),
        .pio_size_err_o(pio_size_err_o), .pio_rdata_o(pio_rdata_o),
        .req_valid_o(req_valid_o), .req_ready_i(req_ready_i), .req_epoch_o(req_epoch_o),
        .rsp_valid_i(rsp_valid_i), .rsp_data_i(rsp_data_i), .rsp_epoch_i(rsp_epoch_i)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit finished = 0;

    // responder: fixed latency, data = D000_0000 | epoch<<20 | per-command index
    int lat = 5;
    int tcnt = 0;
    int idx [2];
    int nreq [2];
    int p_due [64];
    logic [31:0] p_dat [64];
    logic p_ep [64];
    int hd = 0, tl = 0;
    logic exp_ep = 1'b0;

    initial begin idx[0] = 0; idx[1] = 0; nreq[0] = 0; nreq[1] = 0; end

    always begin
        @(negedge clk);
        #1;
        rsp_valid_i = 1'b0;
        if (rst_n) begin
            if (hd != tl && p_due[hd % 64] <= tcnt) begin
                rsp_valid_i = 1'b1;
                rsp_data_i  = p_dat[hd % 64];
                rsp_epoch_i = p_ep[hd % 64];
                hd++;
            end
            if (req_valid_o && req_ready_i) begin
                p_due[tl % 64] = tcnt + lat;
                p_dat[tl % 64] = 32'hD000_0000 | (32'(req_epoch_o) << 20) | 32'(idx[req_epoch_o]);
                p_ep[tl % 64]  = req_epoch_o;
                idx[req_epoch_o]++;
                nreq[req_epoch_o]++;
                tl++;
            end
            tcnt++;
        end
    end

    function automatic logic [31:0] exp_data(input logic ep, input int k);
        return 32'hD000_0000 | (32'(ep) << 20) | 32'(k);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cmd_write(input logic [1:0] m, input logic [7:0] op);
        @(negedge clk);
        mode_i = m;
        pio_valid_i = 1'b1; pio_write_i = 1'b1; pio_addr_i = CPORT;
        pio_be_i = 4'h1; pio_wdata_i = {24'h0, op};
        exp_ep = ~exp_ep;
        idx[exp_ep] = 0;
        nreq[exp_ep] = 0;
        @(negedge clk);
        pio_valid_i = 1'b0;
    endtask

    // kind: 1 ack, 2 retry, 3 size error, 0 none
    task automatic rd(input logic [3:0] be, output int kind, output logic [31:0] data);
        @(negedge clk);
        pio_valid_i = 1'b1; pio_write_i = 1'b0; pio_addr_i = DPORT; pio_be_i = be;
        @(negedge clk);
        pio_valid_i = 1'b0;
        kind = pio_ack_o ? 1 : pio_retry_o ? 2 : pio_size_err_o ? 3 : 0;
        data = pio_rdata_o;
    endtask

    task automatic rd_wait(output logic [31:0] data, output bit got);
        int kind;
        got = 0;
        data = '0;
        for (int t = 0; t < 100; t++) begin
            rd(4'hF, kind, data);
            if (kind == 1) begin got = 1; break; end
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int kind;
        logic [31:0] d;
        bit got;
        int depth;

        // R1 reset state
        idle(3);
        chk({pio_ack_o, pio_retry_o, pio_size_err_o, req_valid_o} == 4'b0, "R1 reset outputs",
            {28'h0, pio_ack_o, pio_retry_o, pio_size_err_o, req_valid_o}, 32'h0);
        rst_n = 1'b1;
        idle(2);
        chk(req_valid_o == 1'b0 && req_epoch_o == 1'b0, "R1 idle after reset",
            {30'h0, req_valid_o, req_epoch_o}, 32'h0);

        // R2 / R3 sweep: all mode codes against read and non-read opcodes
        begin
            logic [7:0] ops [8];
            ops[0] = 8'h20; ops[1] = 8'hC4; ops[2] = 8'hE4; ops[3] = 8'hEC;
            ops[4] = 8'h30; ops[5] = 8'hC5; ops[6] = 8'h00; ops[7] = 8'hE5;
            for (int m = 0; m < 4; m++) begin
                for (int o = 0; o < 8; o++) begin
                    cmd_write(2'(m), ops[o]);
                    idle(20);
                    depth = (o < 3) ? ((m == 1) ? 2 : (m == 2) ? 3 : 0) : 0;
                    chk(nreq[exp_ep] == depth, "R2 R3 prime depth", 32'(nreq[exp_ep]), 32'(depth));
                end
            end
        end

        // R4 / R7: consumption at each depth keeps the pipeline full, FIFO order
        for (int m = 1; m < 3; m++) begin
            depth = m + 1;
            cmd_write(2'(m), 8'hC4);
            idle(20);
            for (int k = 0; k < 6; k++) begin
                rd_wait(d, got);
                chk(got && d == exp_data(exp_ep, k), "R7 queued data order", d, exp_data(exp_ep, k));
                idle(15);
                chk(nreq[exp_ep] == k + 1 + depth, "R4 replacement request",
                    32'(nreq[exp_ep]), 32'(k + 1 + depth));
            end
        end

        // R7 back-to-back reads drain then retry
        cmd_write(2'b01, 8'h20);
        idle(20);
        rd(4'hF, kind, d);
        chk(kind == 1 && d == exp_data(exp_ep, 0), "R7 first ack", d, exp_data(exp_ep, 0));
        rd(4'hF, kind, d);
        chk(kind == 1 && d == exp_data(exp_ep, 1), "R7 second ack", d, exp_data(exp_ep, 1));
        rd(4'hF, kind, d);
        chk(kind == 2, "R7 empty queue retry", 32'(kind), 32'd2);

        // R5 sector limit, then fallback to demand (R9)
        cmd_write(2'b01, 8'hE4);
        for (int k = 0; k < 128; k++) begin
            rd_wait(d, got);
            chk(got && d == exp_data(exp_ep, k), "R5 sector data", d, exp_data(exp_ep, k));
        end
        idle(20);
        chk(nreq[exp_ep] == 128, "R5 request cap", 32'(nreq[exp_ep]), 32'd128);
        rd_wait(d, got);
        chk(got && d == exp_data(exp_ep, 128), "R9 demand after sector", d, exp_data(exp_ep, 128));
        chk(nreq[exp_ep] == 129, "R9 single demand request", 32'(nreq[exp_ep]), 32'd129);

        // R9 demand path with prefetch off
        cmd_write(2'b00, 8'h20);
        idle(10);
        rd(4'hF, kind, d);
        chk(kind == 2, "R9 demand first retry", 32'(kind), 32'd2);
        for (int k = 0; k < 3; k++) begin
            rd_wait(d, got);
            chk(got && d == exp_data(exp_ep, k), "R9 demand data", d, exp_data(exp_ep, k));
            chk(nreq[exp_ep] == k + 1, "R9 one request per read", 32'(nreq[exp_ep]), 32'(k + 1));
        end

        // R8 partial read in prefetch mode, and accepted when disabled
        cmd_write(2'b01, 8'h20);
        idle(20);
        rd(4'h3, kind, d);
        chk(kind == 3, "R8 partial read size error", 32'(kind), 32'd3);
        rd(4'hF, kind, d);
        chk(kind == 1 && d == exp_data(exp_ep, 0), "R8 nothing consumed", d, exp_data(exp_ep, 0));
        cmd_write(2'b00, 8'h20);
        rd(4'h3, kind, d);
        rd_wait(d, got);
        chk(got && d == exp_data(exp_ep, 0), "R8 partial accepted when off", d, exp_data(exp_ep, 0));

        // R6 flush with responses in flight
        lat = 8;
        cmd_write(2'b10, 8'h20);
        idle(2);
        cmd_write(2'b01, 8'h20);
        chk(req_epoch_o == exp_ep, "R6 epoch toggled", {31'h0, req_epoch_o}, {31'h0, exp_ep});
        idle(30);
        chk(nreq[exp_ep] == 2, "R6 fresh prime after flush", 32'(nreq[exp_ep]), 32'd2);
        for (int k = 0; k < 3; k++) begin
            rd_wait(d, got);
            chk(got && d == exp_data(exp_ep, k), "R6 no stale data", d, exp_data(exp_ep, k));
        end
        lat = 5;

        // R10 mode change without command write
        cmd_write(2'b10, 8'h20);
        idle(20);
        mode_i = 2'b00;
        rd_wait(d, got);
        idle(20);
        chk(nreq[exp_ep] == 4, "R10 mode latched", 32'(nreq[exp_ep]), 32'd4);

        // R11 request held while not ready
        req_ready_i = 1'b0;
        cmd_write(2'b01, 8'h20);
        idle(6);
        chk(req_valid_o == 1'b1 && nreq[exp_ep] == 0, "R11 request held",
            {31'h0, req_valid_o}, 32'h1);
        req_ready_i = 1'b1;
        idle(20);
        chk(nreq[exp_ep] == 2, "R11 resumes on ready", 32'(nreq[exp_ep]), 32'd2);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule